// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Modes

A synchronous RAM with two independent ports, A and B, that share one storage array. Each port has an enable, a write enable, an address, a data word and a parity field on input. It has a registered data output and a registered parity output. Parity bits are stored and returned together with the data bits. A per-port parameter decides what that port's output register loads when the port writes. It can load the freshly written word (write-first), the word the location held before the write (read-first), or nothing, keeping the previous output (no-change).

Both ports run on one common clock, so a same-address access by the two ports on the same edge is a well-defined event. When one port writes the address the other port reads, the reading port receives the old contents only if the writer is read-first. Otherwise the reading port's output is undefined, and its collision flag is set. When both ports write the same address, both flags are set and the stored word is undefined. Undefined values are driven as all X in simulation. The flags are one-cycle pulses that line up with the invalid output.

Top module: `dpram_wm`

## Requirements
- R1: While rst_n is low, every data output, parity output and collision flag is zero.
- R2: On an edge where a port is enabled and not writing, and no collision applies to it, the stored word at its address appears on its outputs after that edge.
- R3: A write-first port that writes shows the written data and parity on its outputs after the same edge.
- R4: A read-first port that writes shows the location's previous contents on its outputs, and the location holds the new word afterwards.
- R5: A no-change port that writes keeps its outputs unchanged, and the location holds the new word afterwards.
- R6: A port whose enable is low neither writes nor reads. Its outputs hold, its flag is low, and the stored words are untouched whatever its write enable, address and data are.
- R7: Parity is stored and returned with the data under the same mode rules. Within the bench's 9-bit word, parity is bit 8 and data is bits 7:0.
- R8: When port X reads an address that port Y writes on the same edge and Y is read-first, X receives the old contents and X's flag stays low.
- R9: When port X reads an address that port Y writes on the same edge and Y is write-first or no-change, X's collision flag is high for exactly the following cycle and X's data is undefined.
- R10: When both ports write the same address on the same edge, both collision flags go high for the following cycle, both outputs are undefined, and the stored word is undefined until it is rewritten.
- R11: A collision flag is high only in the cycle after an edge on which both ports were enabled with equal addresses and the other port was writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock common to both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A address |
| a_din | input | DW | Port A write data |
| a_pin | input | PW | Port A write parity |
| a_dout | output | DW | Port A registered read data |
| a_pout | output | PW | Port A registered read parity |
| a_coll | output | 1 | Port A output-invalid flag |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B address |
| b_din | input | DW | Port B write data |
| b_pin | input | PW | Port B write parity |
| b_dout | output | DW | Port B registered read data |
| b_pout | output | PW | Port B registered read parity |
| b_coll | output | 1 | Port B output-invalid flag |

## Verification
A wrong output register shows on the port one edge after the access that loaded it, because every output is registered. A wrong stored word stays hidden until some port later reads that address. For that reason each write sweep is followed by read sweeps over every address, so that corrupted storage cannot go unobserved. A mistaken collision decision shows as a flag mismatch in the very next cycle. The bench runs two instances with complementary mode settings so that every mode takes part both as writer and as the colliding partner.

// File: rtl/dpram_wm_pkg.sv
package dpram_wm_pkg;
    typedef enum logic [1:0] {
        WM_WRITE_FIRST = 2'd0,
        WM_READ_FIRST  = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;
endpackage

// File: rtl/dpram_wm_array.sv
module dpram_wm_array #(
    parameter int AW = 9,
    parameter int WW = 9
) (
    input  logic          clk,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [WW-1:0] a_word,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [WW-1:0] b_word,
    output logic [WW-1:0] a_rd,
    output logic [WW-1:0] b_rd
);
    localparam int DEPTH = 1 << AW;

    logic [WW-1:0] cells [DEPTH];
    logic          clash;

    assign clash = a_wr && b_wr && (a_addr == b_addr);

    // Two writers to one cell on one edge leave that cell undefined.
    always_ff @(posedge clk) begin
        if (clash) begin
            cells[a_addr] <= {WW{1'bx}};
        end else begin
            if (a_wr) cells[a_addr] <= a_word;
            if (b_wr) cells[b_addr] <= b_word;
        end
    end

    assign a_rd = cells[a_addr];
    assign b_rd = cells[b_addr];
endmodule

// File: rtl/dpram_wm_port.sv
module dpram_wm_port
    import dpram_wm_pkg::*;
#(
    parameter int     AW         = 9,
    parameter int     WW         = 9,
    parameter wmode_e MODE       = WM_WRITE_FIRST,
    parameter wmode_e MODE_OTHER = WM_WRITE_FIRST
) (
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [WW-1:0] wword,
    input  logic [WW-1:0] rword,
    input  logic [WW-1:0] held,
    input  logic          o_en,
    input  logic          o_we,
    input  logic [AW-1:0] o_addr,
    output logic [WW-1:0] word_d,
    output logic          flag_d
);
    logic same_cell;
    logic spoiled;

    assign same_cell = en && o_en && (addr == o_addr);
    // Output is lost if the partner writes here, unless only the
    // partner writes and it reads before writing.
    assign spoiled = same_cell && o_we && (we || (MODE_OTHER != WM_READ_FIRST));

    always_comb begin
        word_d = held;
        flag_d = 1'b0;
        if (en) begin
            if (spoiled) begin
                word_d = {WW{1'bx}};
                flag_d = 1'b1;
            end else if (!we) begin
                word_d = rword;
            end else begin
                case (MODE)
                    WM_WRITE_FIRST: word_d = wword;
                    WM_READ_FIRST:  word_d = rword;
                    default:        word_d = held;
                endcase
            end
        end
    end
endmodule

// File: rtl/dpram_wm.sv
module dpram_wm
    import dpram_wm_pkg::*;
#(
    parameter int     DW     = 8,
    parameter int     PW     = 1,
    parameter int     AW     = 9,
    parameter wmode_e MODE_A = WM_WRITE_FIRST,
    parameter wmode_e MODE_B = WM_WRITE_FIRST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_en,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_din,
    input  logic [PW-1:0] a_pin,
    output logic [DW-1:0] a_dout,
    output logic [PW-1:0] a_pout,
    output logic          a_coll,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_din,
    input  logic [PW-1:0] b_pin,
    output logic [DW-1:0] b_dout,
    output logic [PW-1:0] b_pout,
    output logic          b_coll
);
    localparam int     WW       = DW + PW;
    localparam wmode_e MODES[2] = '{MODE_A, MODE_B};

    typedef struct packed {
        logic [1:0][WW-1:0] word;
        logic [1:0]         flag;
    } state_t;

    state_t st_d, st_q;

    logic          en   [2];
    logic          we   [2];
    logic [AW-1:0] addr [2];
    logic [WW-1:0] wword[2];
    logic [WW-1:0] rword[2];
    logic [WW-1:0] nword[2];
    logic          nflag[2];

    assign en[0]    = a_en;
    assign en[1]    = b_en;
    assign we[0]    = a_we;
    assign we[1]    = b_we;
    assign addr[0]  = a_addr;
    assign addr[1]  = b_addr;
    assign wword[0] = {a_pin, a_din};
    assign wword[1] = {b_pin, b_din};

    dpram_wm_array #(.AW(AW), .WW(WW)) u_array (
        .clk    (clk),
        .a_wr   (a_en && a_we),
        .a_addr (a_addr),
        .a_word (wword[0]),
        .b_wr   (b_en && b_we),
        .b_addr (b_addr),
        .b_word (wword[1]),
        .a_rd   (rword[0]),
        .b_rd   (rword[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_port
        dpram_wm_port #(
            .AW         (AW),
            .WW         (WW),
            .MODE       (MODES[g]),
            .MODE_OTHER (MODES[1-g])
        ) u_port (
            .en     (en[g]),
            .we     (we[g]),
            .addr   (addr[g]),
            .wword  (wword[g]),
            .rword  (rword[g]),
            .held   (st_q.word[g]),
            .o_en   (en[1-g]),
            .o_we   (we[1-g]),
            .o_addr (addr[1-g]),
            .word_d (nword[g]),
            .flag_d (nflag[g])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < 2; i++) begin
            st_d.word[i] = nword[i];
            st_d.flag[i] = nflag[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_dout = st_q.word[0][DW-1:0];
    assign a_pout = st_q.word[0][WW-1:DW];
    assign a_coll = st_q.flag[0];
    assign b_dout = st_q.word[1][DW-1:0];
    assign b_pout = st_q.word[1][WW-1:DW];
    assign b_coll = st_q.flag[1];
endmodule

// File: rtl/dpram_wm_chk.sv
module dpram_wm_chk
    import dpram_wm_pkg::*;
#(
    parameter int     DW     = 8,
    parameter int     PW     = 1,
    parameter int     AW     = 9,
    parameter wmode_e MODE_A = WM_WRITE_FIRST,
    parameter wmode_e MODE_B = WM_WRITE_FIRST
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_din,
    input logic [PW-1:0] a_pin,
    input logic [DW-1:0] a_dout,
    input logic [PW-1:0] a_pout,
    input logic          a_coll,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_din,
    input logic [PW-1:0] b_pin,
    input logic [DW-1:0] b_dout,
    input logic [PW-1:0] b_pout,
    input logic          b_coll
);
    logic same, both_wr;
    assign same    = a_en && b_en && (a_addr == b_addr);
    assign both_wr = same && a_we && b_we;

    a_r6_a_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> ($stable(a_dout) && $stable(a_pout) && !a_coll));
    a_r6_b_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> ($stable(b_dout) && $stable(b_pout) && !b_coll));

    a_r3_a_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_A == WM_WRITE_FIRST && a_en && a_we && !both_wr)
        |=> (a_dout == $past(a_din) && a_pout == $past(a_pin)));
    a_r3_b_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_B == WM_WRITE_FIRST && b_en && b_we && !both_wr)
        |=> (b_dout == $past(b_din) && b_pout == $past(b_pin)));

    a_r5_a_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_A == WM_NO_CHANGE && a_en && a_we && !both_wr)
        |=> ($stable(a_dout) && $stable(a_pout)));
    a_r5_b_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_B == WM_NO_CHANGE && b_en && b_we && !both_wr)
        |=> ($stable(b_dout) && $stable(b_pout)));

    a_r8_a_old_data_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !a_we && b_we && MODE_B == WM_READ_FIRST) |=> !a_coll);
    a_r9_a_flag_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !a_we && b_we && MODE_B != WM_READ_FIRST) |=> a_coll);
    a_r9_b_flag_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (same && !b_we && a_we && MODE_A != WM_READ_FIRST) |=> b_coll);

    a_r10_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
        both_wr |=> (a_coll && b_coll));

    a_r11_a_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(same && b_we) |=> !a_coll);
    a_r11_b_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !(same && a_we) |=> !b_coll);

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (a_dout == '0 && a_pout == '0 && !a_coll
                                     && b_dout == '0 && b_pout == '0 && !b_coll);
        end
    end
endmodule

bind dpram_wm dpram_wm_chk #(
    .DW(DW), .PW(PW), .AW(AW), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
    .a_dout(a_dout), .a_pout(a_pout), .a_coll(a_coll),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
    .b_dout(b_dout), .b_pout(b_pout), .b_coll(b_coll)
);

// File: tb/tb_dpram_wm.sv
module tb_dpram_wm;
    import dpram_wm_pkg::*;

    localparam int DW = 8;
    localparam int PW = 1;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int WF = 0, RF = 1, NC = 2;
    // Instance 0: A write-first, B read-first. Instance 1: both no-change.
    localparam int MD[2][2] = '{'{WF, RF}, '{NC, NC}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_din = '0, b_din = '0;
    logic [PW-1:0] a_pin = '0, b_pin = '0;

    logic [DW-1:0] dout[2][2];
    logic [PW-1:0] pout[2][2];
    logic          coll[2][2];

    dpram_wm #(.DW(DW), .PW(PW), .AW(AW),
               .MODE_A(WM_WRITE_FIRST), .MODE_B(WM_READ_FIRST)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(dout[0][0]), .a_pout(pout[0][0]), .a_coll(coll[0][0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(dout[0][1]), .b_pout(pout[0][1]), .b_coll(coll[0][1]));

    dpram_wm #(.DW(DW), .PW(PW), .AW(AW),
               .MODE_A(WM_NO_CHANGE), .MODE_B(WM_NO_CHANGE)) dut_nc (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_din(a_din), .a_pin(a_pin),
        .a_dout(dout[1][0]), .a_pout(pout[1][0]), .a_coll(coll[1][0]),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_din(b_din), .b_pin(b_pin),
        .b_dout(dout[1][1]), .b_pout(pout[1][1]), .b_coll(coll[1][1]));

    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;
    logic [8:0] bm[N];
    logic [8:0] prev[2][2];
    bit         known[2][2];

    function automatic logic [8:0] pat(input int i, input int mul, input int add);
        return 9'((i * mul + add) & 9'h1FF);
    endfunction

    task automatic check_word(input string req, input int d, input int p,
                              input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s inst%0d port%0d word got=%h exp=%h", req, d, p, got, exp);
        end
    endtask

    task automatic check_flag(input string req, input int d, input int p,
                              input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s inst%0d port%0d flag got=%b exp=%b", req, d, p, got, exp);
        end
    endtask

    task automatic step(input string req,
                        input bit ea, input bit wa, input int aa, input logic [8:0] da,
                        input bit eb, input bit wb, input int ab, input logic [8:0] db);
        bit         en[2];
        bit         we[2];
        int         ad[2];
        logic [8:0] di[2];
        logic [8:0] ed[2][2];
        bit         ef[2][2];
        bit         ek[2][2];
        en = '{ea, eb}; we = '{wa, wb}; ad = '{aa, ab}; di = '{da, db};
        a_en = ea; a_we = wa; a_addr = AW'(aa); {a_pin, a_din} = da;
        b_en = eb; b_we = wb; b_addr = AW'(ab); {b_pin, b_din} = db;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                int q = 1 - p;
                bit same = en[p] && en[q] && (ad[p] == ad[q]);
                bit bad = same && we[q] && (we[p] || MD[d][q] != RF);
                ed[d][p] = prev[d][p];
                ek[d][p] = known[d][p];
                ef[d][p] = 1'b0;
                if (en[p]) begin
                    if (bad) begin
                        ef[d][p] = 1'b1;
                        ek[d][p] = 1'b0;
                    end else if (!we[p] || MD[d][p] == RF) begin
                        ed[d][p] = bm[ad[p]];
                        ek[d][p] = 1'b1;
                    end else if (MD[d][p] == WF) begin
                        ed[d][p] = di[p];
                        ek[d][p] = 1'b1;
                    end
                end
            end
        end
        @(posedge clk);
        if (!(en[0] && we[0] && en[1] && we[1] && ad[0] == ad[1])) begin
            if (en[0] && we[0]) bm[ad[0]] = di[0];
            if (en[1] && we[1]) bm[ad[1]] = di[1];
        end
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                check_flag(req, d, p, coll[d][p], ef[d][p]);
                if (ek[d][p]) check_word(req, d, p, {pout[d][p], dout[d][p]}, ed[d][p]);
                prev[d][p]  = ek[d][p] ? {pout[d][p], dout[d][p]} : 9'h0;
                known[d][p] = ek[d][p];
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) bm[i] = 9'h0;
        repeat (3) @(negedge clk);
        // R1: all outputs zero during reset
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                check_flag("R1", d, p, coll[d][p], 1'b0);
                check_word("R1", d, p, {pout[d][p], dout[d][p]}, 9'h0);
                prev[d][p]  = 9'h0;
                known[d][p] = 1'b1;
            end
        end
        rst_n = 1'b1;
        @(negedge clk);
        // Fill through A: write-first echoes, no-change holds; parity varies
        for (int i = 0; i < N; i++) step("R3 R5 R7", 1, 1, i, pat(i, 37, 5), 0, 0, 0, 9'h0);
        // Read every word back through B
        for (int i = 0; i < N; i++) step("R2 R7", 0, 0, 0, 9'h0, 1, 0, i, 9'h0);
        // B writes (read-first / no-change) while A reads a neighbouring cell
        for (int i = 0; i < N; i++)
            step("R4 R5 R2", 1, 0, i ^ 1, 9'h0, 1, 1, i, pat(i, 91, 200));
        // Disabled ports with write enable and data: nothing may change
        for (int i = 0; i < N; i++)
            step("R6", 0, 1, i, 9'h1AA, 0, 1, i ^ 3, 9'h055);
        for (int i = 0; i < N; i++) step("R6 R2 R4", 1, 0, i, 9'h0, 0, 1, i, 9'h1FF);
        // A writes the cell B reads
        for (int i = 0; i < N; i++)
            step("R9 R3", 1, 1, i, pat(i, 53, 17), 1, 0, i, 9'h0);
        // B writes the cell A reads
        for (int i = 0; i < N; i++)
            step("R8 R9 R4", 1, 0, i, 9'h0, 1, 1, i, pat(i, 29, 300));
        // Both write different cells: no flags
        step("R11", 1, 1, 2, 9'h133, 1, 1, 3, 9'h0C4);
        // Both write one cell
        step("R10", 1, 1, 5, 9'h111, 1, 1, 5, 9'h0EE);
        step("R10 R11", 1, 1, 5, 9'h1C3, 0, 0, 0, 9'h0);
        step("R10 R2", 0, 0, 0, 9'h0, 1, 0, 5, 9'h0);
        for (int i = 0; i < N; i++) step("R2 R11", 1, 0, i, 9'h0, 1, 0, N - 1 - i, 9'h0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule